// File: doc/BRIEF.md
# Byte-Lane Steering Memory Slave

This block is a 16-bit-wide memory slave for a parallel system bus shared by 8-bit and 16-bit bus masters. Each access carries an active-low byte-high-enable and an active-low address bit 0. The slave decodes the pair into an even-byte, odd-byte or full-word transfer. Bytes are routed so that the even byte sits on data bits 7..0 and the odd byte on bits 15..8. An 8-bit master reaching an odd address is served through a swap path that moves the odd byte onto bits 7..0, so 8-bit masters only ever use the low lane.

The slave holds a small internal RAM built from two byte lanes. It answers active-low memory read and write commands. It pulls its active-low transfer acknowledge low a fixed, parameter-set number of clock edges after it first sees the command, and holds it low until the master releases the command. The clock is the bus's free-running constant clock. The bus is split into an input data path and an output data path with an output-enable, so a pad ring can build the shared data lines.

Top module: `byteLaneRamSlave`

## Requirements
- R1: With byteHighEnN=1 and addr0N=1 (8-bit even), a read drives the word's even byte on dataOut[7:0] and zero on dataOut[15:8].
- R2: With byteHighEnN=1 and addr0N=0 (8-bit odd), a read drives the word's odd byte on dataOut[7:0] and zero on dataOut[15:8].
- R3: With byteHighEnN=0 and addr0N=1 (16-bit), a read drives {odd byte, even byte} on dataOut[15:0].
- R4: A write stores only the lanes its transfer type selects. An 8-bit even write takes dataIn[7:0] into the even byte. An 8-bit odd write takes dataIn[7:0] into the odd byte. A 16-bit write takes dataIn[7:0] into the even byte and dataIn[15:8] into the odd byte. All other bytes are unchanged.
- R5: The pair byteHighEnN=0 with addr0N=0 is illegal. Such a command is never acknowledged, never writes and never drives the data bus.
- R6: For a legal command first sampled active at clock edge 1, xackN goes low after edge ACK_DELAY. It stays low while the command stays active, and returns high after the first edge at which the command is sampled released.
- R7: dataOe is high only while exactly one command, a read, is active with a legal transfer type.
- R8: After reset, xackN is high and dataOe is low.
- R9: A command with read and write both active is never acknowledged and never writes.
- R10: A write released before its acknowledge leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Constant bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordAddr | input | ADDR_W | Word address (address bits above bit 0) |
| addr0N | input | 1 | Active-low address bit 0 (high = even) |
| byteHighEnN | input | 1 | Active-low byte-high-enable |
| memRdCmdN | input | 1 | Active-low memory read command |
| memWrCmdN | input | 1 | Active-low memory write command |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data toward the bus |
| dataOe | output | 1 | Output enable for dataOut |
| xackN | output | 1 | Active-low transfer acknowledge |

## Verification
The bench builds the block with ADDR_W=4 and ACK_DELAY=3. Sixteen words let a short run revisit every address many times with mixed byte and word writes, so lane isolation errors show up on later reads. A three-edge delay leaves two edges before the acknowledge, which is enough to check that xackN is still high on the edge before it falls and to release a write before it is acknowledged.

// File: rtl/laneSteerPkg.sv
package laneSteerPkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int BUS_W  = BYTE_W * LANES;

  typedef enum logic [1:0] {
    XFER_EVEN8 = 2'd0,
    XFER_ODD8  = 2'd1,
    XFER_WORD  = 2'd2,
    XFER_BAD   = 2'd3
  } xferKindE;

  typedef struct packed {
    logic wrEven;    // store even lane this edge
    logic wrOdd;     // store odd lane this edge
    logic driveBus;  // read data onto the bus
    logic swapLo;    // odd byte travels on the low lane
    logic driveHi;   // high lane carries the odd byte
  } laneStrobeT;
endpackage

// File: rtl/laneDecode.sv
module laneDecode
  import laneSteerPkg::*;
(
  input  logic     byteHighEnN,
  input  logic     addr0N,
  output xferKindE xferKind
);
  always_comb begin
    unique case ({byteHighEnN, addr0N})
      2'b11:   xferKind = XFER_EVEN8;
      2'b10:   xferKind = XFER_ODD8;
      2'b01:   xferKind = XFER_WORD;
      default: xferKind = XFER_BAD;
    endcase
  end
endmodule

// File: rtl/slaveCtrl.sv
module slaveCtrl
  import laneSteerPkg::*;
#(
  parameter int ACK_DELAY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdCmdN,
  input  logic       wrCmdN,
  input  xferKindE   xferKind,
  output laneStrobeT strobes,
  output logic       xackN
);
  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACK_DELAY - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_HOLD} ctrlStateE;

  ctrlStateE        st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             cmdRd, cmdWr, cmdAny, legalCmd, ackEnter;

  assign cmdRd    = !rdCmdN && wrCmdN;
  assign cmdWr    = !wrCmdN && rdCmdN;
  assign cmdAny   = !rdCmdN || !wrCmdN;
  assign legalCmd = (cmdRd || cmdWr) && (xferKind != XFER_BAD);

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    unique case (st)
      ST_IDLE: begin
        if (legalCmd) begin
          if (ACK_DELAY <= 1) stNext = ST_ACK;
          else begin
            stNext  = ST_WAIT;
            cntNext = ONE_CNT;
          end
        end else if (cmdAny) begin
          stNext = ST_HOLD;
        end
      end
      ST_WAIT: begin
        if (!legalCmd)            stNext = cmdAny ? ST_HOLD : ST_IDLE;
        else if (cnt == LAST_CNT) stNext = ST_ACK;
        else                      cntNext = cnt + ONE_CNT;
      end
      ST_ACK:  if (!cmdAny) stNext = ST_IDLE;
      ST_HOLD: if (!cmdAny) stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  assign ackEnter = (stNext == ST_ACK) && (st != ST_ACK);

  always_comb begin
    strobes.wrEven   = ackEnter && cmdWr &&
                       (xferKind == XFER_EVEN8 || xferKind == XFER_WORD);
    strobes.wrOdd    = ackEnter && cmdWr &&
                       (xferKind == XFER_ODD8 || xferKind == XFER_WORD);
    strobes.driveBus = cmdRd && (xferKind != XFER_BAD);
    strobes.swapLo   = (xferKind == XFER_ODD8);
    strobes.driveHi  = (xferKind == XFER_WORD);
  end

  assign xackN = (st != ST_ACK);
endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import laneSteerPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [BUS_W-1:0]  dataIn,
  input  laneStrobeT        strobes,
  output logic [BUS_W-1:0]  dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] wrByte [LANES];
  logic [BYTE_W-1:0] rdByte [LANES];
  logic [LANES-1:0]  wrLane;

  assign wrLane    = {strobes.wrOdd, strobes.wrEven};
  assign wrByte[0] = dataIn[BYTE_W-1:0];
  assign wrByte[1] = strobes.swapLo ? dataIn[BYTE_W-1:0] : dataIn[BUS_W-1:BYTE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (wrLane[g]) laneMem[wordAddr] <= wrByte[g];
    end
    assign rdByte[g] = laneMem[wordAddr];
  end

  always_comb begin
    dataOut = '0;
    if (strobes.driveBus) begin
      dataOut[BYTE_W-1:0]     = strobes.swapLo ? rdByte[1] : rdByte[0];
      dataOut[BUS_W-1:BYTE_W] = strobes.driveHi ? rdByte[1] : '0;
    end
  end
endmodule

// File: rtl/byteLaneRamSlave.sv
module byteLaneRamSlave
  import laneSteerPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ACK_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              addr0N,
  input  logic              byteHighEnN,
  input  logic              memRdCmdN,
  input  logic              memWrCmdN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  output logic              xackN
);
  xferKindE   xferKind;
  laneStrobeT ctlStrobe;

  laneDecode u_decode (
    .byteHighEnN (byteHighEnN),
    .addr0N      (addr0N),
    .xferKind    (xferKind)
  );

  slaveCtrl #(.ACK_DELAY(ACK_DELAY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdCmdN   (memRdCmdN),
    .wrCmdN   (memWrCmdN),
    .xferKind (xferKind),
    .strobes  (ctlStrobe),
    .xackN    (xackN)
  );

  laneDatapath #(.ADDR_W(ADDR_W)) u_data (
    .clk      (clk),
    .wordAddr (wordAddr),
    .dataIn   (dataIn),
    .strobes  (ctlStrobe),
    .dataOut  (dataOut)
  );

  assign dataOe = ctlStrobe.driveBus;
endmodule

// File: rtl/laneSteerChecker.sv
module laneSteerChecker
  import laneSteerPkg::*;
#(
  parameter int ACK_DELAY = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       memRdCmdN,
  input logic       memWrCmdN,
  input logic       byteHighEnN,
  input logic       addr0N,
  input logic       xackN,
  input logic       dataOe,
  input laneStrobeT strobes
);
  localparam int RUN_W = $clog2(ACK_DELAY + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(ACK_DELAY + 1);

  logic             cmdAny;
  logic [RUN_W-1:0] runCnt;

  assign cmdAny = !memRdCmdN || !memWrCmdN;

  always_ff @(posedge clk) begin
    if (!rstN)                  runCnt <= '0;
    else if (!cmdAny)           runCnt <= '0;
    else if (runCnt != RUN_SAT) runCnt <= runCnt + RUN_W'(1);
  end

  p_ack_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xackN) |-> (runCnt == RUN_W'(ACK_DELAY)));

  p_ack_needs_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    !xackN |-> $past(cmdAny));

  p_no_ack_bad_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xackN) |-> $past(byteHighEnN || addr0N));

  p_no_ack_both_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xackN) |-> $past(memRdCmdN != memWrCmdN));

  p_write_single_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEven || strobes.wrOdd) |-> (!memWrCmdN && memRdCmdN));

  p_odd_only_lane_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrOdd && !strobes.wrEven) |-> (byteHighEnN && !addr0N));

  p_even_only_lane_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEven && !strobes.wrOdd) |-> (byteHighEnN && addr0N));

  p_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!memRdCmdN && memWrCmdN && (byteHighEnN || addr0N)));
endmodule

bind byteLaneRamSlave laneSteerChecker #(.ACK_DELAY(ACK_DELAY)) u_laneChk (
  .clk         (clk),
  .rstN        (rstN),
  .memRdCmdN   (memRdCmdN),
  .memWrCmdN   (memWrCmdN),
  .byteHighEnN (byteHighEnN),
  .addr0N      (addr0N),
  .xackN       (xackN),
  .dataOe      (dataOe),
  .strobes     (ctlStrobe)
);

// File: tb/test_byteLaneRamSlave.sv
module test_byteLaneRamSlave;
  localparam int AW    = 4;
  localparam int DLY   = 3;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] wordAddr = '0;
  logic          addr0N = 1'b1, byteHighEnN = 1'b1;
  logic          memRdCmdN = 1'b1, memWrCmdN = 1'b1;
  logic [15:0]   dataIn = '0;
  logic [15:0]   dataOut;
  logic          dataOe, xackN;

  int testsRun = 0, testsFailed = 0;
  logic [7:0] mLo [WORDS];
  logic [7:0] mHi [WORDS];

  always #2 clk = ~clk;

  byteLaneRamSlave #(.ADDR_W(AW), .ACK_DELAY(DLY)) i_byteLaneRamSlave (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .addr0N(addr0N),
    .byteHighEnN(byteHighEnN), .memRdCmdN(memRdCmdN), .memWrCmdN(memWrCmdN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .xackN(xackN)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string typeTag(input bit bhen, input bit a0);
    if (bhen && a0) return "R1";
    if (bhen)       return "R2";
    return "R3";
  endfunction

  function automatic logic [15:0] expRead(input int a, input bit bhen, input bit a0);
    if (bhen && a0) return {8'h00, mLo[a]};
    if (bhen)       return {8'h00, mHi[a]};
    return {mHi[a], mLo[a]};
  endfunction

  task automatic modelWrite(input int a, input bit bhen, input bit a0, input logic [15:0] d);
    if (bhen && a0)  mLo[a] = d[7:0];
    else if (bhen)   mHi[a] = d[7:0];
    else begin mLo[a] = d[7:0]; mHi[a] = d[15:8]; end
  endtask

  task automatic idle();
    memRdCmdN = 1'b1; memWrCmdN = 1'b1;
  endtask

  // Full legal bus cycle with R6 timing checks.
  task automatic busCycle(input bit isWr, input int a, input bit bhen, input bit a0,
                          input logic [15:0] wd);
    @(negedge clk);
    wordAddr = AW'(a); byteHighEnN = bhen; addr0N = a0; dataIn = wd;
    memRdCmdN = isWr; memWrCmdN = !isWr;
    for (int i = 1; i <= DLY; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == DLY - 1) check("R6 xack before delay", {15'd0, xackN}, 16'd1);
      if (i == DLY)     check("R6 xack at delay", {15'd0, xackN}, 16'd0);
    end
    if (isWr) check("R7 no drive on write", {15'd0, dataOe}, 16'd0);
    else begin
      check("R7 drive on read", {15'd0, dataOe}, 16'd1);
      check(typeTag(bhen, a0), dataOut, expRead(a, bhen, a0));
    end
    @(posedge clk); @(negedge clk);
    check("R6 xack held", {15'd0, xackN}, 16'd0);
    idle();
    if (isWr) modelWrite(a, bhen, a0, wd);
    #0;
    check("R7 no drive after release", {15'd0, dataOe}, 16'd0);
    @(posedge clk); @(negedge clk);
    check("R6 xack release", {15'd0, xackN}, 16'd1);
  endtask

  // Command that must never be acknowledged (R5 / R9).
  task automatic deadCycle(input string req, input bit rd, input bit wr, input int a,
                           input bit bhen, input bit a0, input logic [15:0] wd);
    @(negedge clk);
    wordAddr = AW'(a); byteHighEnN = bhen; addr0N = a0; dataIn = wd;
    memRdCmdN = !rd; memWrCmdN = !wr;
    for (int i = 0; i < DLY + 4; i++) begin
      @(posedge clk); @(negedge clk);
    end
    check({req, " no ack"}, {15'd0, xackN}, 16'd1);
    check({req, " no drive"}, {15'd0, dataOe}, 16'd0);
    @(negedge clk); idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20931));
    #(4 * 150000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 xack after reset", {15'd0, xackN}, 16'd1);
    check("R8 no drive after reset", {15'd0, dataOe}, 16'd0);
    rstN = 1'b1;

    // Fill RAM with word writes (R4, R3)
    for (int a = 0; a < WORDS; a++) busCycle(1'b1, a, 1'b0, 1'b1, 16'(a * 16'h0935 + 16'h1200));
    for (int a = 0; a < WORDS; a++) busCycle(1'b0, a, 1'b0, 1'b1, 16'h0);

    // Directed lane writes: R4 even byte, odd byte via swap, high lane junk ignored
    busCycle(1'b1, 5, 1'b1, 1'b1, 16'hEEA5);
    busCycle(1'b1, 5, 1'b1, 1'b0, 16'hDD3C);
    busCycle(1'b0, 5, 1'b0, 1'b1, 16'h0);
    check("R4 lanes word 5", {mHi[5], mLo[5]}, 16'h3CA5);
    busCycle(1'b0, 5, 1'b1, 1'b0, 16'h0);
    busCycle(1'b0, 5, 1'b1, 1'b1, 16'h0);

    // R5 illegal pair, read and write
    deadCycle("R5 read", 1'b1, 1'b0, 7, 1'b0, 1'b0, 16'h0);
    deadCycle("R5 write", 1'b0, 1'b1, 7, 1'b0, 1'b0, 16'hBEEF);
    busCycle(1'b0, 7, 1'b0, 1'b1, 16'h0);
    // R9 both commands active
    deadCycle("R9 both", 1'b1, 1'b1, 7, 1'b0, 1'b1, 16'hCAFE);
    busCycle(1'b0, 7, 1'b0, 1'b1, 16'h0);

    // R10 write released before acknowledge
    @(negedge clk);
    wordAddr = AW'(9); byteHighEnN = 1'b0; addr0N = 1'b1; dataIn = 16'h7777;
    memWrCmdN = 1'b0;
    for (int i = 0; i < DLY - 1; i++) begin @(posedge clk); @(negedge clk); end
    check("R10 no ack yet", {15'd0, xackN}, 16'd1);
    idle();
    @(posedge clk); @(negedge clk);
    busCycle(1'b0, 9, 1'b0, 1'b1, 16'h0);
    check("R10 model untouched", {mHi[9], mLo[9]}, 16'(9 * 16'h0935 + 16'h1200));

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int a, k;
      bit wr;
      a  = int'($urandom_range(WORDS - 1, 0));
      k  = int'($urandom_range(2, 0));
      wr = 1'($urandom_range(1, 0));
      busCycle(wr, a, (k != 2), (k != 1), 16'($urandom()));
    end

    // Final sweep of all words (R4)
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      wordAddr = AW'(a); byteHighEnN = 1'b0; addr0N = 1'b1; memRdCmdN = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R4 final sweep", dataOut, {mHi[a], mLo[a]});
      idle();
      repeat (2) @(posedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule